// File: doc/BRIEF.md
# Qualified serial shift slice

This block is one serial-to-parallel shift lane whose shifting is gated by a qualifier. On each system clock where the shift enable is high and the final qualifier is 1, the serial data bit is taken in. A bit counter tracks how many bits have arrived. When a word of programmable length is complete, the block copies the shift register to a parallel output and raises a one-clock completion pulse.

The qualifier comes from a 2-bit mode field. Mode 0 forces it to 1, mode 1 forces it to 0, mode 2 follows a signal from a neighbouring slice, and mode 3 follows an external pin. A separate invert bit complements the selected qualifier after the mode multiplexer. With inversion on, the two constant modes therefore swap meaning: mode 0 blocks shifting and mode 1 lets it through. A typical use feeds an active-low chip-select from another slice into mode 2 with inversion on, so that data is captured only during a transfer.

All four data inputs are registered on the system clock before they are used. The configuration fields are read directly at each edge.

Top module: `qss_slice`

## Requirements
- R1: With mode 0 and invert 0, every sampled shift enable causes a shift.
- R2: With mode 1 and invert 0, no shift happens: the bit counter holds, word_done stays 0 and data_out does not change.
- R3: Mode 2 uses the sampled slice_qual and mode 3 uses the sampled pin_qual as the qualifier. A shift happens only when the qualifier is 1.
- R4: Invert 1 complements the selected qualifier. Mode 0 then blocks all shifts, mode 1 passes every sampled enable, and modes 2 and 3 shift when their input is 0.
- R5: Each qualified shift moves the register right by one place and puts the new bit in the MSB. For a full word, the first bit received ends in bit 0.
- R6: After cfg_len_m1+1 qualified shifts, data_out takes the register value that includes the last bit, and word_done is 1 for exactly that one clock. The count then starts again.
- R7: An input applied before clock edge k is sampled at edge k, and its shift and any completion appear after edge k+1.
- R8: Synchronous reset clears data_out, the shift register and the counter, and forces word_done to 0.
- R9: A change of cfg_mode or cfg_inv while no enable is sampled causes no shift and no completion.
- R10: Enables that are blocked by the qualifier are not counted, so a word spread across blocked cycles still completes after exactly cfg_len_m1+1 qualified shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Qualifier mode: 0 always on, 1 always off, 2 slice input, 3 pin input |
| cfg_inv | input | 1 | Complements the selected qualifier when 1 |
| cfg_len_m1 | input | CNT_W (3) | Word length minus one |
| shift_en | input | 1 | Shift clock enable |
| sdi | input | 1 | Serial data in |
| slice_qual | input | 1 | Qualifier from the neighbouring slice |
| pin_qual | input | 1 | Qualifier from the external pin |
| data_out | output | WIDTH (8) | Last completed word |
| word_done | output | 1 | One-clock pulse when a word completes |

## Verification
An enable, data bit or qualifier driven before edge k is registered at edge k and acts at edge k+1. The bench therefore drives on falling edges and reads word_done and data_out at the falling edge that follows edge k+1, and once more one cycle later to confirm the pulse has ended. The qualifier table uses one-bit words, so every qualified enable must give a pulse on that exact cycle. Gaps inside a word are made through the slice input, which is registered together with the enable. Configuration changes are made only while no enable is pending, so each change acts on a known cycle.

// File: rtl/qss_pkg.sv
package qss_pkg;
  typedef enum logic [1:0] {
    QM_ON    = 2'd0,
    QM_OFF   = 2'd1,
    QM_SLICE = 2'd2,
    QM_PIN   = 2'd3
  } qual_mode_e;
endpackage

// File: rtl/qss_qual_sel.sv
module qss_qual_sel
  import qss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       inv,
  input  logic       shift_en,
  input  logic       sdi,
  input  logic       slice_qual,
  input  logic       pin_qual,
  output logic       sdi_s,
  output logic       shift_go
);
  logic en_s, slq_s, pnq_s;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_s  <= 1'b0;
      sdi_s <= 1'b0;
      slq_s <= 1'b0;
      pnq_s <= 1'b0;
    end else begin
      en_s  <= shift_en;
      sdi_s <= sdi;
      slq_s <= slice_qual;
      pnq_s <= pin_qual;
    end
  end

  // Mode constants are chosen first; inversion acts on the mux output.
  always_comb begin
    unique case (qual_mode_e'(mode))
      QM_ON:    sel_q = 1'b1;
      QM_OFF:   sel_q = 1'b0;
      QM_SLICE: sel_q = slq_s;
      QM_PIN:   sel_q = pnq_s;
      default:  sel_q = 1'b0;
    endcase
  end

  assign shift_go = en_s & (sel_q ^ inv);
endmodule

// File: rtl/qss_bit_counter.sv
module qss_bit_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] len_m1,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = (cnt >= len_m1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (step)
      cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/qss_shift_reg.sv
module qss_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             din,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] q;

  assign nxt[WIDTH-1] = din;
  generate
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_lane
      assign nxt[i] = q[i+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (step)
      q <= nxt;
  end
endmodule

// File: rtl/qss_slice.sv
module qss_slice #(
  parameter int WIDTH = 8,
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_inv,
  input  logic [CNT_W-1:0] cfg_len_m1,
  input  logic             shift_en,
  input  logic             sdi,
  input  logic             slice_qual,
  input  logic             pin_qual,
  output logic [WIDTH-1:0] data_out,
  output logic             word_done
);
  logic             sdi_s;
  logic             shift_go;
  logic             last;
  logic [WIDTH-1:0] nxt;

  qss_qual_sel u_qual (
    .clk        (clk),
    .rst        (rst),
    .mode       (cfg_mode),
    .inv        (cfg_inv),
    .shift_en   (shift_en),
    .sdi        (sdi),
    .slice_qual (slice_qual),
    .pin_qual   (pin_qual),
    .sdi_s      (sdi_s),
    .shift_go   (shift_go)
  );

  qss_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (shift_go),
    .len_m1 (cfg_len_m1),
    .last   (last)
  );

  qss_shift_reg #(.WIDTH(WIDTH)) u_sr (
    .clk  (clk),
    .rst  (rst),
    .step (shift_go),
    .din  (sdi_s),
    .nxt  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= shift_go & last;
      if (shift_go && last)
        data_out <= nxt;
    end
  end
endmodule

// File: rtl/qss_slice_chk.sv
module qss_slice_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_mode,
  input logic             cfg_inv,
  input logic             shift_en,
  input logic             pin_qual,
  input logic             shift_go,
  input logic [WIDTH-1:0] data_out,
  input logic             word_done
);
  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!word_done && data_out == '0));

  // R2
  no_shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_go |=> (!word_done && $stable(data_out)));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(shift_go));

  // R1
  mode_on_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(shift_en) && cfg_mode == 2'd0 && !cfg_inv) |-> shift_go);

  // R4
  inv_off_passes_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(shift_en) && cfg_mode == 2'd1 && cfg_inv) |-> shift_go);

  // R3
  pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cfg_mode == 2'd3 && !cfg_inv) |-> (shift_go == ($past(shift_en) && $past(pin_qual))));
endmodule

bind qss_slice qss_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_mode  (cfg_mode),
  .cfg_inv   (cfg_inv),
  .shift_en  (shift_en),
  .pin_qual  (pin_qual),
  .shift_go  (shift_go),
  .data_out  (data_out),
  .word_done (word_done)
);

// File: tb/tb_qss_slice.sv
module tb_qss_slice;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] cfg_mode;
  logic cfg_inv;
  logic [CNT_W-1:0] cfg_len_m1;
  logic shift_en, sdi, slice_qual, pin_qual;
  logic [WIDTH-1:0] data_out;
  logic word_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qss_slice #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
    .cfg_len_m1(cfg_len_m1), .shift_en(shift_en), .sdi(sdi),
    .slice_qual(slice_qual), .pin_qual(pin_qual),
    .data_out(data_out), .word_done(word_done)
  );

  // {mode, inv, slice, pin, expected shift}
  localparam logic [5:0] VEC [16] = '{
    {2'd0,1'b0,1'b0,1'b0,1'b1}, {2'd0,1'b1,1'b1,1'b1,1'b0},
    {2'd1,1'b0,1'b1,1'b1,1'b0}, {2'd1,1'b1,1'b0,1'b0,1'b1},
    {2'd2,1'b0,1'b1,1'b0,1'b1}, {2'd2,1'b0,1'b0,1'b1,1'b0},
    {2'd2,1'b1,1'b1,1'b0,1'b0}, {2'd2,1'b1,1'b0,1'b1,1'b1},
    {2'd3,1'b0,1'b0,1'b1,1'b1}, {2'd3,1'b0,1'b1,1'b0,1'b0},
    {2'd3,1'b1,1'b0,1'b1,1'b0}, {2'd3,1'b1,1'b1,1'b0,1'b1},
    {2'd0,1'b0,1'b1,1'b1,1'b1}, {2'd1,1'b0,1'b0,1'b0,1'b0},
    {2'd0,1'b1,1'b0,1'b0,1'b0}, {2'd1,1'b1,1'b1,1'b1,1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; shift_en = 1'b0; sdi = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Streams n bits LSB first with slice_qual per bit from gate; ends just before the completion edge.
  task automatic stream(input logic [15:0] bits, input logic [15:0] gate, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shift_en = 1'b1; sdi = bits[i]; slice_qual = gate[i];
    end
    @(negedge clk);
    shift_en = 1'b0; sdi = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_len_m1 = '0;
    shift_en = 1'b0; sdi = 1'b0; slice_qual = 1'b0; pin_qual = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset data_out", 32'(data_out), 32'h0);
    check("R8 reset word_done", 32'(word_done), 32'h0);

    // Qualifier table, one-bit words (R1 R2 R3 R4 R7)
    for (int v = 0; v < 16; v++) begin
      do_reset();
      cfg_len_m1 = '0;
      cfg_mode = VEC[v][5:4]; cfg_inv = VEC[v][3];
      slice_qual = VEC[v][2]; pin_qual = VEC[v][1];
      shift_en = 1'b1; sdi = 1'b1;
      @(negedge clk);
      shift_en = 1'b0; sdi = 1'b0;
      check("R7 no early done", 32'(word_done), 32'h0);
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 qualifier vector %0d done", v), 32'(word_done), 32'(VEC[v][0]));
      check($sformatf("R4 vector %0d data", v), 32'(data_out), VEC[v][0] ? 32'h80 : 32'h0);
      @(negedge clk);
      check("R6 pulse one cycle", 32'(word_done), 32'h0);
    end

    // Full word through mode 0 (R5 R6)
    do_reset();
    cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_len_m1 = 3'd7;
    stream(16'h00A5, 16'hFFFF, 8);
    check("R6 no done before last", 32'(word_done), 32'h0);
    @(negedge clk);
    check("R6 word done", 32'(word_done), 32'h1);
    check("R5 word order", 32'(data_out), 32'hA5);
    @(negedge clk);
    check("R6 done clears", 32'(word_done), 32'h0);

    // Second word after reload (R6)
    stream(16'h003C, 16'hFFFF, 8);
    @(negedge clk);
    check("R6 reload done", 32'(word_done), 32'h1);
    check("R6 reload data", 32'(data_out), 32'h3C);

    // Short words: 4 bits into the MSB half (R5 R6)
    do_reset();
    cfg_len_m1 = 3'd3;
    stream(16'h0009, 16'hFFFF, 4);
    @(negedge clk);
    check("R6 short done", 32'(word_done), 32'h1);
    check("R5 short data", 32'(data_out), 32'h90);

    // Gaps blocked by slice qualifier inside a word (R10 R3)
    do_reset();
    cfg_mode = 2'd2; cfg_inv = 1'b0; cfg_len_m1 = 3'd7;
    // qualified bits 0..3 = 1,0,1,0 ; three blocked ones ; bits 4..7 = 0,1,1,0
    stream(16'b0_0110_111_0101, 16'b1_1111_000_1111, 11);
    @(negedge clk);
    check("R10 gapped word done", 32'(word_done), 32'h1);
    check("R10 gapped word data", 32'(data_out), 32'h65);

    // Config change alone does nothing (R9)
    cfg_len_m1 = '0;
    @(negedge clk);
    cfg_mode = 2'd0; cfg_inv = 1'b1;
    @(negedge clk);
    cfg_mode = 2'd1;
    @(negedge clk);
    check("R9 no done on config change", 32'(word_done), 32'h0);
    cfg_inv = 1'b0;
    @(negedge clk);
    check("R9 data unchanged", 32'(data_out), 32'h65);
    check("R9 no done later", 32'(word_done), 32'h0);

    // Counter holds while disabled (R2 R10)
    do_reset();
    cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_len_m1 = 3'd1;
    stream(16'h0001, 16'hFFFF, 1);
    @(negedge clk);
    cfg_mode = 2'd1;
    stream(16'h0000, 16'hFFFF, 3);
    @(negedge clk);
    check("R2 disabled no done", 32'(word_done), 32'h0);
    cfg_mode = 2'd0;
    stream(16'h0001, 16'hFFFF, 1);
    @(negedge clk);
    check("R10 count held done", 32'(word_done), 32'h1);
    check("R10 count held data", 32'(data_out), 32'hC0);

    // Reset mid-stream (R8)
    stream(16'h0001, 16'hFFFF, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid reset done", 32'(word_done), 32'h0);
    check("R8 mid reset data", 32'(data_out), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule